// File: doc/BRIEF.md
# Half-Bridge Dead-Time Sequencer

This block sits between a control register and the gate drivers of six half-bridge legs. Each leg has a high-side and a low-side switch, and the register holds one requested on/off bit for each. The block turns those requests into gate enables and guarantees that the two switches of a leg are never driven at the same time.

Whenever a gate of a leg switches off, the leg enters a blanking interval. No gate of that leg may switch on until the interval ends. The interval is longer after the low-side switch releases than after the high-side switch releases. Each leg keeps its own timer, so legs switch independently of one another.

A force-off input from the fault supervisor removes all gate drive in the same cycle, with no register in the path. When it releases, the longer interval runs before any gate may switch on again. Interval lengths are given in nanoseconds together with the clock frequency, and the block converts them to clock cycles.

Top module: `hb_deadtime_seq`

## Requirements
- R1: In no cycle are `gate_hs[i]` and `gate_ls[i]` both high for the same leg i (bit i of every vector belongs to leg i).
- R2: For a leg with no blanking pending and both gates low, a request with only one of `req_hs[i]`/`req_ls[i]` set drives that gate high at the next clock edge. Dropping the request of a conducting gate drives that gate low at the next clock edge.
- R3: After a high-side gate falls, neither gate of that leg rises until DT_HL cycles have passed. A pending request then switches its gate on exactly DT_HL cycles after the fall, whether it asks for the opposite side or the same side.
- R4: After a low-side gate falls, the blanking lasts DT_LH cycles, with the same timing as in R3. This is the path taken when a synchronous brake on the low side is followed by high-side drive.
- R5: When both requests of a leg are set together, both gates of that leg go low at the next clock edge and stay low for as long as both requests stay set.
- R6: While `force_off` is high, all twelve gate outputs are low in the same cycle, without waiting for a clock edge. Once it falls, no gate rises until DT_LH clock edges have passed with `force_off` low.
- R7: A change of request during a blanking interval neither shortens nor restarts that interval. The gate for the latest request switches on when the interval ends.
- R8: Each leg is sequenced independently. A leg that is ready switches on at the next edge even while another leg is blanking.
- R9: After reset all gate outputs are low and no blanking is pending.
- R10: DT_HL and DT_LH are the nanosecond parameters times CLK_HZ, divided by 10^9 and rounded up, with a minimum of 1. The defaults give 75 and 125 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_hs | input | NUM_LEGS | Requested high-side state per leg |
| req_ls | input | NUM_LEGS | Requested low-side state per leg |
| force_off | input | 1 | Fault force-off, removes all drive at once |
| gate_hs | output | NUM_LEGS | High-side gate enable per leg |
| gate_ls | output | NUM_LEGS | Low-side gate enable per leg |

## Verification
The main function is exercised with these patterns:
- High-to-low and low-to-high swaps. Measuring their exact cycle counts separates the two interval lengths and shows which side selects which length.
- A release followed by a same-side request. This shows that blanking depends on the gate that fell, not on the side asked for next.
- A request that flips back in the middle of a blanking interval. This tells a timer that restarts apart from one that runs on.
- Both requests set together, and force-off held and then released. These check the safe-off paths.
- A turn-on in one leg while a neighbour leg is blanking. This shows that the legs share no timer.

// File: rtl/hb_seq_pkg.sv
// Package: shared types and helpers for the half-bridge dead-time sequencer.
// Assumes: frequencies in Hz and intervals in ns fit comfortably in 64 bits.
package hb_seq_pkg;

    // Decoded per-leg command
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_HIGH = 2'd1,
        CMD_LOW  = 2'd2
    } leg_cmd_e;

    // Convert a nanosecond interval to clock cycles, rounded up, minimum one
    function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 64'd0) c = 64'd1;
        return c[31:0];
    endfunction

endpackage

// File: rtl/hb_cmd_decode.sv
// Module: maps one leg's pair of request bits to a single command.
// Assumes: both bits set is an invalid request and means idle (both off).
module hb_cmd_decode
    import hb_seq_pkg::*;
(
    input  logic     req_hs,
    input  logic     req_ls,
    output leg_cmd_e cmd
);

    // Pick the command; conflicting or empty requests collapse to idle
    always_comb begin
        unique case ({req_hs, req_ls})
            2'b10:   cmd = CMD_HIGH;
            2'b01:   cmd = CMD_LOW;
            default: cmd = CMD_IDLE;
        endcase
    end

endmodule

// File: rtl/hb_blank_timer.sv
// Module: down-counting blanking timer for one leg.
// Assumes: load_val is the interval minus one; ready is high when no blanking runs.
module hb_blank_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          ready
);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ready = (cnt_q == '0);

endmodule

// File: rtl/hb_leg_seq.sv
// Module: sequences one half-bridge leg.
// Turn-off is immediate. Turn-on waits until the blanking timer is idle.
// Every gate fall loads a blanking interval chosen by the side that fell.
// Assumes: DT_HL_CYC, DT_LH_CYC >= 1 and both fit in CW bits.
module hb_leg_seq
    import hb_seq_pkg::*;
#(
    parameter int unsigned CW        = 8,
    parameter int unsigned DT_HL_CYC = 75,
    parameter int unsigned DT_LH_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hs,
    input  logic req_ls,
    input  logic force_off,
    output logic gate_hs,
    output logic gate_ls
);

    localparam logic [CW-1:0] LOAD_HL = CW'(DT_HL_CYC - 1);
    localparam logic [CW-1:0] LOAD_LH = CW'(DT_LH_CYC - 1);

    leg_cmd_e      cmd;
    logic          hs_q, ls_q, hs_d, ls_d;
    logic          tmr_load, tmr_ready;
    logic [CW-1:0] tmr_val;

    hb_cmd_decode i_dec (
        .req_hs (req_hs),
        .req_ls (req_ls),
        .cmd    (cmd)
    );

    hb_blank_timer #(.CW(CW)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .ready    (tmr_ready)
    );

    // Next gate state and blanking load, in priority order
    always_comb begin
        hs_d     = hs_q;
        ls_d     = ls_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (force_off) begin
            hs_d     = 1'b0;
            ls_d     = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = LOAD_LH;
        end else if (hs_q && cmd != CMD_HIGH) begin
            hs_d     = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = LOAD_HL;
        end else if (ls_q && cmd != CMD_LOW) begin
            ls_d     = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = LOAD_LH;
        end else if (!hs_q && !ls_q && tmr_ready) begin
            hs_d = (cmd == CMD_HIGH);
            ls_d = (cmd == CMD_LOW);
        end
    end

    // Gate state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            ls_q <= 1'b0;
        end else begin
            hs_q <= hs_d;
            ls_q <= ls_d;
        end
    end

    // Force-off masks the registered drive without a clock edge
    assign gate_hs = hs_q & ~force_off;
    assign gate_ls = ls_q & ~force_off;

endmodule

// File: rtl/hb_deadtime_seq.sv
// Module: top of the six-leg dead-time sequencer.
// Converts the interval parameters to cycles and replicates one sequencer per leg.
// Assumes: requests are synchronous to clk.
module hb_deadtime_seq
    import hb_seq_pkg::*;
#(
    parameter int unsigned NUM_LEGS = 6,
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned DT_HL_NS = 1500,
    parameter int unsigned DT_LH_NS = 2500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LEGS-1:0] req_hs,
    input  logic [NUM_LEGS-1:0] req_ls,
    input  logic                force_off,
    output logic [NUM_LEGS-1:0] gate_hs,
    output logic [NUM_LEGS-1:0] gate_ls
);

    localparam int unsigned DT_HL_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(DT_HL_NS));
    localparam int unsigned DT_LH_CYC = ns_to_cycles(longint'(CLK_HZ), longint'(DT_LH_NS));
    localparam int unsigned DT_MAX    = (DT_HL_CYC > DT_LH_CYC) ? DT_HL_CYC : DT_LH_CYC;
    localparam int unsigned CW        = $clog2(DT_MAX + 1);

    // One independent sequencer per leg
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hb_leg_seq #(
            .CW        (CW),
            .DT_HL_CYC (DT_HL_CYC),
            .DT_LH_CYC (DT_LH_CYC)
        ) i_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_hs    (req_hs[g]),
            .req_ls    (req_ls[g]),
            .force_off (force_off),
            .gate_hs   (gate_hs[g]),
            .gate_ls   (gate_ls[g])
        );
    end

endmodule

// File: rtl/hb_seq_checker.sv
// Module: assertion checker bound to hb_deadtime_seq.
// It measures the off-time before each gate rise with its own per-leg counter.
// Assumes: the same interval parameters as the bound instance.
module hb_seq_checker
    import hb_seq_pkg::*;
#(
    parameter int unsigned NUM_LEGS = 6,
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned DT_HL_NS = 1500,
    parameter int unsigned DT_LH_NS = 2500
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_LEGS-1:0] req_hs,
    input logic [NUM_LEGS-1:0] req_ls,
    input logic                force_off,
    input logic [NUM_LEGS-1:0] gate_hs,
    input logic [NUM_LEGS-1:0] gate_ls
);

    localparam int unsigned HL  = ns_to_cycles(longint'(CLK_HZ), longint'(DT_HL_NS));
    localparam int unsigned LH  = ns_to_cycles(longint'(CLK_HZ), longint'(DT_LH_NS));
    localparam int unsigned MX  = (HL > LH) ? HL : LH;
    localparam int unsigned CW  = $clog2(MX + 1);
    localparam logic [CW-1:0] SAT  = CW'(MX);
    localparam logic [CW-1:0] HL_C = CW'(HL);
    localparam logic [CW-1:0] LH_C = CW'(LH);

    // R6: force-off clears every gate within the cycle
    p_force_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> (gate_hs == '0 && gate_ls == '0));

    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_chk
        logic [CW-1:0] since_q;
        logic          last_hs_q;

        // Count cycles with the leg fully off; remember which side held it last
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                since_q   <= SAT;
                last_hs_q <= 1'b0;
            end else if (force_off || gate_hs[i] || gate_ls[i]) begin
                since_q   <= '0;
                last_hs_q <= gate_hs[i];
            end else if (since_q != SAT) begin
                since_q <= since_q + 1'b1;
            end
        end

        // R1: no shoot-through
        p_no_shoot_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hs[i] && gate_ls[i]));

        // R3 and R4: off-time before a rise covers the interval of the side that fell
        p_blank_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_hs[i]) || $rose(gate_ls[i])) |->
                (since_q >= (last_hs_q ? HL_C : LH_C)));

        // R2: a gate only rises for a single-side request of its own side
        p_rise_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hs[i]) |-> $past(req_hs[i] && !req_ls[i]));
        p_rise_ls_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_ls[i]) |-> $past(req_ls[i] && !req_hs[i]));

        // R5: conflicting requests leave the leg off
        p_both_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_hs[i] && req_ls[i]) |=> (!gate_hs[i] && !gate_ls[i]));
    end

endmodule

bind hb_deadtime_seq hb_seq_checker #(
    .NUM_LEGS (NUM_LEGS),
    .CLK_HZ   (CLK_HZ),
    .DT_HL_NS (DT_HL_NS),
    .DT_LH_NS (DT_LH_NS)
) i_hb_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_hs    (req_hs),
    .req_ls    (req_ls),
    .force_off (force_off),
    .gate_hs   (gate_hs),
    .gate_ls   (gate_ls)
);

// File: tb/test_hb_deadtime_seq.sv
// Bench: directed scenarios, one task each, for hb_deadtime_seq.
module test_hb_deadtime_seq;

    localparam int NL  = 6;
    // R10: expected interval lengths at 50 MHz, rounded up
    localparam int EXP_HL = (50 * 1500 + 999) / 1000;
    localparam int EXP_LH = (50 * 2500 + 999) / 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] req_hs = '0;
    logic [NL-1:0] req_ls = '0;
    logic          force_off = 1'b0;
    logic [NL-1:0] gate_hs, gate_ls;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hb_deadtime_seq i_hb_deadtime_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_hs    (req_hs),
        .req_ls    (req_ls),
        .force_off (force_off),
        .gate_hs   (gate_hs),
        .gate_ls   (gate_ls)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Count sampled cycles until the chosen gate of a leg is high
    task automatic wait_rise(input int leg, input bit hs_side, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!(hs_side ? gate_hs[leg] : gate_ls[leg]) && n < 400);
    endtask

    task automatic settle();
        req_hs = '0;
        req_ls = '0;
        force_off = 1'b0;
        repeat (200) step();
    endtask

    task automatic t_reset();
        step();
        chk(gate_hs == '0 && gate_ls == '0, "R9 gates low after reset", {gate_hs, gate_ls}, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_turn_on();
        int n;
        req_hs[0] = 1'b1;
        wait_rise(0, 1'b1, n);
        chk(n == 1, "R2 R9 ready leg turns on next edge", n, 1);
    endtask

    task automatic t_hs_to_ls();
        int n;
        req_hs[0] = 1'b0;
        req_ls[0] = 1'b1;
        wait_rise(0, 1'b0, n);
        chk(n == EXP_HL + 1, "R3 R10 high-to-low blanking", n, EXP_HL + 1);
        chk(!gate_hs[0], "R1 high side off with low side on", gate_hs[0], 0);
    endtask

    task automatic t_ls_to_hs();
        int n;
        req_ls[0] = 1'b0;
        req_hs[0] = 1'b1;
        wait_rise(0, 1'b1, n);
        chk(n == EXP_LH + 1, "R4 R10 low-to-high blanking after brake", n, EXP_LH + 1);
    endtask

    task automatic t_both();
        req_ls[0] = 1'b1;
        step();
        chk(!gate_hs[0] && !gate_ls[0], "R5 both requested turns leg off", {gate_hs[0], gate_ls[0]}, 0);
        repeat (200) step();
        chk(!gate_hs[0] && !gate_ls[0], "R5 leg stays off while both requested", {gate_hs[0], gate_ls[0]}, 0);
        settle();
    endtask

    task automatic t_force();
        int n;
        req_hs[0] = 1'b1;
        req_ls[3] = 1'b1;
        step();
        chk(gate_hs[0] && gate_ls[3], "R2 setup before force", {gate_hs[0], gate_ls[3]}, 3);
        force_off = 1'b1;
        #1;
        chk(gate_hs == '0 && gate_ls == '0, "R6 force clears gates at once", {gate_hs, gate_ls}, 0);
        repeat (10) step();
        chk(gate_hs == '0 && gate_ls == '0, "R6 gates stay low under force", {gate_hs, gate_ls}, 0);
        force_off = 1'b0;
        wait_rise(0, 1'b1, n);
        chk(n == EXP_LH, "R6 blanking after force release", n, EXP_LH);
        chk(gate_ls[3], "R8 other leg recovers in same cycle", gate_ls[3], 1);
        settle();
    endtask

    task automatic t_mid_change();
        int n;
        req_hs[1] = 1'b1;
        step();
        req_hs[1] = 1'b0;
        req_ls[1] = 1'b1;
        n = 0;
        repeat (30) begin
            step();
            n++;
        end
        chk(!gate_hs[1] && !gate_ls[1], "R7 leg off mid blanking", {gate_hs[1], gate_ls[1]}, 0);
        req_ls[1] = 1'b0;
        req_hs[1] = 1'b1;
        while (!gate_hs[1] && n < 400) begin
            step();
            n++;
        end
        chk(n == EXP_HL + 1, "R7 changed request does not restart blanking", n, EXP_HL + 1);
        settle();
    endtask

    task automatic t_same_side();
        int n;
        req_hs[2] = 1'b1;
        step();
        req_hs[2] = 1'b0;
        step();
        chk(!gate_hs[2], "R2 dropped request turns gate off next edge", gate_hs[2], 0);
        req_hs[2] = 1'b1;
        wait_rise(2, 1'b1, n);
        chk(n == EXP_HL, "R3 same-side return still blanked", n, EXP_HL);
        settle();
    endtask

    task automatic t_independent();
        int n;
        req_hs[4] = 1'b1;
        step();
        req_hs[4] = 1'b0;
        req_ls[4] = 1'b1;
        repeat (5) step();
        req_hs[5] = 1'b1;
        wait_rise(5, 1'b1, n);
        chk(n == 1, "R8 ready leg switches while neighbour blanks", n, 1);
        chk(!gate_ls[4] && !gate_hs[4], "R8 blanking leg still off", {gate_hs[4], gate_ls[4]}, 0);
        settle();
    endtask

    initial begin
        t_reset();
        t_turn_on();
        t_hs_to_ls();
        t_ls_to_hs();
        t_both();
        t_force();
        t_mid_change();
        t_same_side();
        t_independent();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule